// File: doc/BRIEF.md
# Audio Control Register Slave (two-wire bus, write only)

This block sits behind the two-wire serial control bus of a stereo audio front end. A host sends a device address, then a subaddress, then data bytes. The block stores those bytes in a small bank of control registers. The register bank drives the analog latches for input source, input gain, volume, bass, treble and the two speaker attenuators as parallel buses.

The clock and data lines are oversampled by the system clock, so the block needs no clock of its own from the bus. The subaddress byte selects one register and sets whether later data bytes advance through the bank or keep overwriting the same register. The block acknowledges every byte of an addressed transfer. It only receives, and it never drives the data line high.

Top module: `audio_ctl_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START seen at any point, including in the middle of a byte, abandons the transfer in progress and begins address reception again.
- R2: After each byte the block accepts, it pulls SDA low (sda_oe = 1) for the whole of the ninth SCL clock. sda_oe changes only while SCL is low and is the only way the block drives the line, which is open drain.
- R3: The block accepts only the address byte 0x88 (7-bit address 0x44 with write bit 0). For any other address byte it does not acknowledge that byte or any later byte, and it writes nothing until the next START.
- R4: In the subaddress byte, bits 3:0 select the register and bit 4 enables auto-increment. Bits 7:5 have no effect.
- R5: With bit 4 clear, every data byte up to the STOP is written to the one selected register, so the last byte sent remains.
- R6: With bit 4 set, the first data byte goes to the sent subaddress and each later byte goes to the previous subaddress plus one, wrapping from 15 to 0. Bytes that land on subaddresses 8 to 15 are acknowledged but change no output.
- R7: The register map is: 0 source select, 1 input gain, 2 volume, 4 bass, 5 treble, 6 right speaker attenuation, 7 left speaker attenuation. A byte written to subaddress 3 changes no output.
- R8: After reset the outputs are sel=0x02, gain=0x0E, vol=0x38 (mute), bass=0x07, treble=0x0E, spk_r=0xF8 (mute) and spk_l=0xF8 (mute), and sda_oe is 0.
- R9: A STOP returns the block to idle and keeps every register already written. A byte cut short by a START or STOP writes nothing, and a transfer that ends after its subaddress changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull data line low when 1 (open drain) |
| sel_q | output | 8 | Source select register (bits 1:0 used) |
| gain_q | output | 8 | Input gain register (bits 3:0 used) |
| vol_q | output | 8 | Volume register |
| bass_q | output | 8 | Bass register (bits 3:0 used) |
| treb_q | output | 8 | Treble register (bits 3:0 used) |
| spk_r_q | output | 8 | Right speaker attenuation register |
| spk_l_q | output | 8 | Left speaker attenuation register |

## Verification
The hardest case to reach from the pins is a START that arrives partway through a data byte. The shift register then holds a few stale bits, and these must never reach a register. The stimulus sends four bits of a byte aimed at the volume register, raises a repeated START, and then runs a full transfer to a different register. This shows that volume kept its value and that the new transfer was decoded from a clean address phase. Long auto-increment bursts that run through the dropped subaddresses 8 to 15 and wrap back to 0 are also built on purpose. The random transfers mix both modes with wrong addresses, empty data phases and random subaddress don't-care bits.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;
  localparam int DW      = 8;             // bits per bus byte
  localparam int NREG    = 8;             // registers held in the bank
  localparam int AW      = $clog2(NREG);  // bank index width
  localparam int SUB_W   = 4;             // subaddress pointer width
  localparam int INC_BIT = 4;             // auto-increment flag position
  localparam int RSV_IDX = 3;             // subaddress with no register

  localparam int IDX_SEL   = 0;
  localparam int IDX_GAIN  = 1;
  localparam int IDX_VOL   = 2;
  localparam int IDX_BASS  = 4;
  localparam int IDX_TREB  = 5;
  localparam int IDX_SPK_R = 6;
  localparam int IDX_SPK_L = 7;

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_SUB, ST_DATA, ST_SKIP} stage_t;
  typedef enum logic [1:0] {AK_NONE, AK_WAIT, AK_HOLD} ack_t;

  function automatic logic [DW-1:0] reg_default(input int idx);
    case (idx)
      IDX_SEL:   return 8'h02;  // second input pair
      IDX_GAIN:  return 8'h0E;  // 28 dB
      IDX_VOL:   return 8'h38;  // mute
      IDX_BASS:  return 8'h07;  // flat
      IDX_TREB:  return 8'h0E;  // +2 dB
      IDX_SPK_R: return 8'hF8;  // mute
      IDX_SPK_L: return 8'hF8;  // mute
      default:   return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_bit,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;
  logic scl_s, sda_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_hi    = scl_s;
  assign sda_bit   = sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/byte_engine.sv
module byte_engine
  import audio_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_hi,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_bit,
  input  logic          start_det,
  input  logic          stop_det,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam logic [SUB_W:0]   LIM   = (SUB_W+1)'(NREG);
  localparam logic [SUB_W-1:0] RSV_L = SUB_W'(RSV_IDX);

  stage_t           stage;
  ack_t             ak;
  logic [2:0]       bit_cnt;
  logic [DW-2:0]    shreg;
  logic [SUB_W-1:0] ptr;
  logic             inc;
  logic             oe_q;
  logic [DW-1:0]    byte_in;
  logic             ptr_ok;

  assign byte_in = {shreg, sda_bit};
  assign ptr_ok  = ({1'b0, ptr} < LIM) && (ptr != RSV_L);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage   <= ST_IDLE;
      ak      <= AK_NONE;
      bit_cnt <= '0;
      shreg   <= '0;
      ptr     <= '0;
      inc     <= 1'b0;
      oe_q    <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        stage   <= ST_ADDR;
        ak      <= AK_NONE;
        bit_cnt <= '0;
        oe_q    <= 1'b0;
      end else if (stop_det) begin
        stage   <= ST_IDLE;
        ak      <= AK_NONE;
        bit_cnt <= '0;
        oe_q    <= 1'b0;
      end else if (stage != ST_IDLE && stage != ST_SKIP) begin
        case (ak)
          AK_NONE: begin
            if (scl_rise) begin
              shreg <= byte_in[DW-2:0];
              if (bit_cnt == 3'd7) begin
                bit_cnt <= '0;
                ak      <= AK_WAIT;
                case (stage)
                  ST_ADDR: begin
                    if (byte_in[7:1] == DEV_ADDR && !byte_in[0]) begin
                      stage <= ST_SUB;
                    end else begin
                      stage <= ST_SKIP;
                      ak    <= AK_NONE;
                    end
                  end
                  ST_SUB: begin
                    ptr   <= byte_in[SUB_W-1:0];
                    inc   <= byte_in[INC_BIT];
                    stage <= ST_DATA;
                  end
                  default: begin
                    wr_en   <= ptr_ok;
                    wr_addr <= ptr[AW-1:0];
                    wr_data <= byte_in;
                    if (inc) ptr <= ptr + 1'b1;
                  end
                endcase
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          AK_WAIT: begin
            if (scl_fall) begin
              oe_q <= 1'b1;
              ak   <= AK_HOLD;
            end
          end
          default: begin
            if (scl_fall) begin
              oe_q <= 1'b0;
              ak   <= AK_NONE;
            end
          end
        endcase
      end
    end
  end

  assign sda_oe = oe_q;

  AST_OE_ONLY_ADDRESSED: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (stage == ST_SUB || stage == ST_DATA)); // R3
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (scl_hi && $past(scl_hi)) |-> $stable(sda_oe)); // R2
  AST_NO_WRITE_OUTSIDE_DATA: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(stage) == ST_DATA); // R9
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
  import audio_ctl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  output logic [NREG-1:0][DW-1:0]  q
);
  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == RSV_IDX) begin : g_rsv
        assign q[i] = reg_default(i);
      end else begin : g_live
        logic [DW-1:0] r;
        always_ff @(posedge clk) begin
          if (rst)                               r <= reg_default(i);
          else if (wr_en && wr_addr == AW'(i))   r <= wr_data;
        end
        assign q[i] = r;

        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
          (wr_en && wr_addr == AW'(i)) |=> q[i] == $past(wr_data)); // R5
        AST_RESET_DEFAULT: assert property (@(posedge clk)
          ($past(rst) && !rst) |-> q[i] == reg_default(i)); // R8
      end
    end
  endgenerate

  AST_NO_RSV_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_addr != AW'(RSV_IDX)); // R7
endmodule

// File: rtl/audio_ctl_slave.sv
module audio_ctl_slave
  import audio_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h44,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [DW-1:0] sel_q,
  output logic [DW-1:0] gain_q,
  output logic [DW-1:0] vol_q,
  output logic [DW-1:0] bass_q,
  output logic [DW-1:0] treb_q,
  output logic [DW-1:0] spk_r_q,
  output logic [DW-1:0] spk_l_q
);
  logic scl_hi, scl_rise, scl_fall, sda_bit, start_det, stop_det;
  logic                    wr_en;
  logic [AW-1:0]           wr_addr;
  logic [DW-1:0]           wr_data;
  logic [NREG-1:0][DW-1:0] regs_q;
  logic                    unused_rsv;

  bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_hi    (scl_hi),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_bit   (sda_bit),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .scl_hi    (scl_hi),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_bit   (sda_bit),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  ctl_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .q       (regs_q)
  );

  assign sel_q      = regs_q[IDX_SEL];
  assign gain_q     = regs_q[IDX_GAIN];
  assign vol_q      = regs_q[IDX_VOL];
  assign bass_q     = regs_q[IDX_BASS];
  assign treb_q     = regs_q[IDX_TREB];
  assign spk_r_q    = regs_q[IDX_SPK_R];
  assign spk_l_q    = regs_q[IDX_SPK_L];
  assign unused_rsv = ^regs_q[RSV_IDX];

  AST_OE_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> !sda_oe); // R8
endmodule

// File: tb/sim_audio_ctl_slave.sv
module sim_audio_ctl_slave;
  localparam int CLK_NS = 10;
  localparam int HALF   = 12;
  localparam int QTR    = 6;
  localparam int LIMIT  = 180000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [7:0] sel_q, gain_q, vol_q, bass_q, treb_q, spk_r_q, spk_l_q;

  assign sda_line = sda_m & ~sda_oe;

  audio_ctl_slave u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .sel_q(sel_q), .gain_q(gain_q), .vol_q(vol_q), .bass_q(bass_q),
    .treb_q(treb_q), .spk_r_q(spk_r_q), .spk_l_q(spk_l_q)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [7:0] exp_r [8];
  logic [7:0] dat [32];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > LIMIT) begin
      n_fail = n_fail + 1;
      $display("FAIL R1 watchdog: actual=still running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] got(input int i);
    case (i)
      0: return sel_q;
      1: return gain_q;
      2: return vol_q;
      4: return bass_q;
      5: return treb_q;
      6: return spk_r_q;
      7: return spk_l_q;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < 8; i++)
      if (i != 3) chk(req, $sformatf("reg%0d", i), got(i), exp_r[i]);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(QTR);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF);
    scl_m = 1'b0; tick(QTR);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(QTR);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    tick(QTR);
    scl_m = 1'b1; tick(HALF);
    scl_m = 1'b0; tick(QTR);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(QTR);
    scl_m = 1'b1; tick(HALF/2);
    acked = ~sda_line;
    tick(HALF/2);
    scl_m = 1'b0; tick(QTR);
  endtask

  // One write transfer; updates the expected bank from the requirements.
  task automatic xfer(input logic [7:0] ab, input logic [7:0] sb, input int n, input string req);
    logic a;
    logic ok;
    logic [3:0] p;
    ok = (ab == 8'h88);                                  // R3
    bus_start;
    send_byte(ab, a);
    chk(req, "addr ack", {7'd0, a}, {7'd0, ok});
    send_byte(sb, a);
    chk(req, "sub ack", {7'd0, a}, {7'd0, ok});
    p = sb[3:0];                                         // R4
    for (int k = 0; k < n; k++) begin
      send_byte(dat[k], a);
      chk(req, "data ack", {7'd0, a}, {7'd0, ok});      // R6 acks on 8..15
      if (ok && p < 4'd8 && p != 4'd3) exp_r[p] = dat[k]; // R7
      if (sb[4]) p = p + 4'd1;                           // R6 wrap
    end
    bus_stop;
    tick(6);
    chk_regs(req);
  endtask

  initial begin
    logic a;
    void'($urandom(32'd2718));
    exp_r[0] = 8'h02; exp_r[1] = 8'h0E; exp_r[2] = 8'h38; exp_r[3] = 8'h00;
    exp_r[4] = 8'h07; exp_r[5] = 8'h0E; exp_r[6] = 8'hF8; exp_r[7] = 8'hF8;
    tick(5);
    rst = 1'b0;
    tick(3);
    chk_regs("R8");
    chk("R8", "sda_oe idle", {7'd0, sda_oe}, 8'h00);

    // R5: three bytes to volume without increment, last stays
    dat[0] = 8'h11; dat[1] = 8'h22; dat[2] = 8'h05;
    xfer(8'h88, 8'h02, 3, "R5");

    // R4: don't-care upper bits, treble, no increment
    dat[0] = 8'h0A; dat[1] = 8'h09;
    xfer(8'h88, 8'hE5, 2, "R4");

    // R7: subaddress 3 changes nothing
    dat[0] = 8'h55; dat[1] = 8'hAA;
    xfer(8'h88, 8'h03, 2, "R7");

    // R6: burst from 2 through the dropped range and wrap to 0,1
    for (int k = 0; k < 18; k++) dat[k] = 8'(8'h40 + k);
    xfer(8'h88, 8'h12, 18, "R6");

    // R3: wrong address, no ack, no write
    dat[0] = 8'h77;
    xfer(8'h8A, 8'h02, 1, "R3");
    xfer(8'h89, 8'h02, 1, "R3");

    // R9: stop right after subaddress
    xfer(8'h88, 8'h16, 0, "R9");

    // R1/R9: START in the middle of a data byte to volume
    bus_start;
    send_byte(8'h88, a);
    send_byte(8'h02, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    dat[0] = 8'h03;
    xfer(8'h88, 8'h05, 1, "R1");
    chk("R9", "vol after abort", vol_q, exp_r[2]);

    // R2: hold ack through ninth clock (sampled early and late)
    bus_start;
    for (int i = 7; i >= 0; i--) send_bit(8'h88 >> i);
    sda_m = 1'b1; tick(QTR);
    chk("R2", "oe before ninth rise", {7'd0, sda_oe}, 8'h01);
    scl_m = 1'b1; tick(HALF - 1);
    chk("R2", "oe late in ninth clock", {7'd0, sda_oe}, 8'h01);
    tick(1);
    scl_m = 1'b0; tick(QTR);
    chk("R2", "oe released", {7'd0, sda_oe}, 8'h00);
    bus_stop;
    tick(4);

    // random mix
    for (int t = 0; t < 40; t++) begin
      logic [7:0] ab;
      logic [7:0] sb;
      int n;
      ab = ($urandom % 6 == 0) ? (8'h88 ^ 8'(1 + $urandom % 255)) : 8'h88;
      sb = 8'($urandom);
      n  = $urandom % 7;
      for (int k = 0; k < n; k++) dat[k] = 8'($urandom);
      xfer(ab, sb, n, sb[4] ? "R6" : "R5");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule